// File: doc/BRIEF.md
# Selectable-Polynomial Reflected CRC Engine

This block keeps a running cyclic redundancy checksum over a stream of data beats handed to it by a separate fetch unit. A two-bit selector picks the generator. The choices are the 32-bit Ethernet polynomial 0x04C11DB7, the 32-bit Castagnoli polynomial 0x1EDC6F41, and the 16-bit CCITT polynomial 0x1021. Every beat is consumed least-significant bit first, so the register is updated in reflected (right-shifting) form. One whole beat is folded in on each clock.

A beat carries 8, 16 or 32 useful bits, as given by a width code. A start strobe presets the register for a new run. When compare mode is on, the value reached on the beat marked last is checked against an expected checksum. A mismatch sets a sticky error flag. That flag reaches the interrupt line only while the interrupt mask is enabled. Separate set and clear strobes control the mask, and its state can be read back. The result output shows the raw register contents, with no final inversion.

Top module: `refl_crc_unit`

## Requirements
- R1: Each accepted beat is folded in reflected form, LSB first, in one clock. The result appears on `crcValue` after the clock edge on which the beat is presented, with no final inversion.
- R2: `cfgPolySel` picks the polynomial: 0 selects Ethernet 32-bit, 1 selects Castagnoli 32-bit, 2 selects CCITT 16-bit, and 3 behaves as 0.
- R3: `beatWidth` sets the beat size: 0 is a byte (bits 7:0), 1 is a halfword (bits 15:0), and 2 or 3 is a word. Bits of `beatData` above the beat size have no effect.
- R4: An accepted `startPulse` presets the register to all ones for the selected width: 0xFFFFFFFF for the 32-bit polynomials, 0x0000FFFF for the 16-bit one. A beat in the same cycle is folded onto the preset value.
- R5: While `cfgEnable` is low, start strobes and beats are ignored, no compare takes place, and `crcValue` holds.
- R6: With `cfgCompare` high, an accepted beat with `beatLast` high compares the updated value with `expectedCrc`. In 16-bit mode only the low 16 bits are compared. A mismatch sets `errStatus` on that same edge. A match leaves it unchanged.
- R7: `errStatus` is sticky. It is cleared only by an accepted start. A mismatch found in the same cycle as the start wins.
- R8: `irqEnSet` sets the mask and `irqEnClr` clears it; if both are high, clear wins. `irqMask` reads the mask back, and `irqOut` is high exactly when both `errStatus` and the mask are set.
- R9: After reset, `crcValue`, `errStatus`, `irqMask` and `irqOut` are all zero.
- R10: In 16-bit mode, bits 31:16 of `crcValue` read zero after a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Engine enable |
| cfgPolySel | input | 2 | Polynomial selector |
| cfgCompare | input | 1 | Compare on last beat |
| startPulse | input | 1 | Preset for a new run |
| beatValid | input | 1 | Beat present this cycle |
| beatData | input | 32 | Beat data, LSB-aligned |
| beatWidth | input | 2 | Beat size code |
| beatLast | input | 1 | Marks the final beat of a run |
| expectedCrc | input | 32 | Value to compare against |
| irqEnSet | input | 1 | Set the interrupt mask |
| irqEnClr | input | 1 | Clear the interrupt mask |
| crcValue | output | 32 | Current register contents |
| errStatus | output | 1 | Sticky compare-mismatch flag |
| irqMask | output | 1 | Mask readback |
| irqOut | output | 1 | Masked error interrupt |

## Verification
The nine-byte ASCII string "123456789" is run under each selector code. The known register values it produces tell the three polynomials apart, show that code 3 aliases code 0, and confirm the 16-bit preset. Random frames mix polynomials, beat widths and garbage in the unused upper data bits. They are checked beat by beat against a bit-serial model, which catches errors in bit order, width gating and seeding. Compare runs use both the model value and a copy of it with one bit flipped inside the polynomial width. This separates match from mismatch and shows that error and interrupt stay set, are masked, and clear on the next start. Directed cycles with the engine disabled, and with start and first beat together, cover the hold and seeding rules.

// File: rtl/refl_crc_pkg.sv
package refl_crc_pkg;

  localparam int CRC_W    = 32;
  localparam int NUM_POLY = 3;
  localparam int SEL_W    = 2;

  localparam logic [SEL_W-1:0] SEL_ETH   = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CAST  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CCITT = 2'd2;

  localparam logic [CRC_W-1:0] POLY_FWD [NUM_POLY] = '{32'h04C11DB7, 32'h1EDC6F41, 32'h00001021};
  localparam int               POLY_LEN [NUM_POLY] = '{32, 32, 16};

  typedef struct packed {
    logic doPreset;
    logic doUpdate;
    logic doCompare;
  } ctlStrobeT;

  function automatic logic [CRC_W-1:0] mirrorLow(input logic [CRC_W-1:0] v, input int len);
    logic [CRC_W-1:0] r;
    r = '0;
    for (int i = 0; i < CRC_W; i++) begin
      if (i < len) r[i] = v[len-1-i];
    end
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] lenMask(input int len);
    return (len >= CRC_W) ? {CRC_W{1'b1}} : ((32'd1 << len) - 32'd1);
  endfunction

  function automatic int beatBits(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] foldBeat(input logic [CRC_W-1:0] seed,
                                                input logic [CRC_W-1:0] data,
                                                input int               nBits,
                                                input logic [CRC_W-1:0] revPoly);
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = seed;
    for (int i = 0; i < CRC_W; i++) begin
      if (i < nBits) begin
        fb  = acc[0] ^ data[i];
        acc = (acc >> 1) ^ (fb ? revPoly : '0);
      end
    end
    return acc;
  endfunction

endpackage

// File: rtl/refl_crc_datapath.sv
module refl_crc_datapath
  import refl_crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobeT        strobe,
  input  logic [SEL_W-1:0] polySel,
  input  logic [CRC_W-1:0] beatData,
  input  logic [1:0]       beatWidth,
  input  logic [CRC_W-1:0] expectedCrc,
  output logic [CRC_W-1:0] crcValue,
  output logic             mismatch
);

  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] seed;
  logic [CRC_W-1:0] crcNext;
  logic [CRC_W-1:0] cand    [NUM_POLY];
  logic [CRC_W-1:0] preset  [NUM_POLY];
  logic [CRC_W-1:0] cmpMask [NUM_POLY];
  int               polyIdx;
  int               nBits;

  always_comb begin
    polyIdx = (polySel == SEL_CCITT) ? 2 : (polySel == SEL_CAST) ? 1 : 0;
    nBits   = beatBits(beatWidth);
  end

  for (genvar p = 0; p < NUM_POLY; p++) begin : g_poly
    localparam logic [CRC_W-1:0] REV  = mirrorLow(POLY_FWD[p], POLY_LEN[p]);
    localparam logic [CRC_W-1:0] ONES = lenMask(POLY_LEN[p]);
    assign preset[p]  = ONES;
    assign cmpMask[p] = ONES;
    assign cand[p]    = foldBeat(seed, beatData, nBits, REV);
  end

  always_comb begin
    seed     = strobe.doPreset ? preset[polyIdx] : crcReg;
    crcNext  = strobe.doUpdate ? cand[polyIdx] : seed;
    mismatch = ((crcNext ^ expectedCrc) & cmpMask[polyIdx]) != '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                crcReg <= '0;
    else if (strobe.doPreset || strobe.doUpdate) crcReg <= crcNext;
  end

  assign crcValue = crcReg;

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.doPreset && !strobe.doUpdate) |=> $stable(crcValue));

  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doPreset && polySel == SEL_CCITT) |=> (crcValue[31:16] == 16'h0));

endmodule

// File: rtl/refl_crc_ctrl.sv
module refl_crc_ctrl
  import refl_crc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfgEnable,
  input  logic      cfgCompare,
  input  logic      startPulse,
  input  logic      beatValid,
  input  logic      beatLast,
  input  logic      irqEnSet,
  input  logic      irqEnClr,
  input  logic      mismatch,
  output ctlStrobeT strobe,
  output logic      errStatus,
  output logic      irqMask,
  output logic      irqOut
);

  logic errReg;
  logic maskReg;

  always_comb begin
    strobe.doPreset  = cfgEnable & startPulse;
    strobe.doUpdate  = cfgEnable & beatValid;
    strobe.doCompare = cfgEnable & beatValid & beatLast & cfgCompare;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            errReg <= 1'b0;
    else if (strobe.doCompare && mismatch) errReg <= 1'b1;
    else if (strobe.doPreset)              errReg <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        maskReg <= 1'b0;
    else if (irqEnClr) maskReg <= 1'b0;
    else if (irqEnSet) maskReg <= 1'b1;
  end

  assign errStatus = errReg;
  assign irqMask   = maskReg;
  assign irqOut    = errReg & maskReg;

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (errStatus && !strobe.doPreset) |=> errStatus);

  a_r6_rise_needs_compare: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(errStatus) |-> $past(strobe.doCompare));

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    irqEnClr |=> !irqMask);

  a_r8_set_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (irqEnSet && !irqEnClr) |=> irqMask);

endmodule

// File: rtl/refl_crc_unit.sv
module refl_crc_unit
  import refl_crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfgEnable,
  input  logic [1:0]  cfgPolySel,
  input  logic        cfgCompare,
  input  logic        startPulse,
  input  logic        beatValid,
  input  logic [31:0] beatData,
  input  logic [1:0]  beatWidth,
  input  logic        beatLast,
  input  logic [31:0] expectedCrc,
  input  logic        irqEnSet,
  input  logic        irqEnClr,
  output logic [31:0] crcValue,
  output logic        errStatus,
  output logic        irqMask,
  output logic        irqOut
);

  ctlStrobeT strobe;
  logic      mismatch;

  refl_crc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgEnable  (cfgEnable),
    .cfgCompare (cfgCompare),
    .startPulse (startPulse),
    .beatValid  (beatValid),
    .beatLast   (beatLast),
    .irqEnSet   (irqEnSet),
    .irqEnClr   (irqEnClr),
    .mismatch   (mismatch),
    .strobe     (strobe),
    .errStatus  (errStatus),
    .irqMask    (irqMask),
    .irqOut     (irqOut)
  );

  refl_crc_datapath u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .polySel     (cfgPolySel),
    .beatData    (beatData),
    .beatWidth   (beatWidth),
    .expectedCrc (expectedCrc),
    .crcValue    (crcValue),
    .mismatch    (mismatch)
  );

endmodule

// File: tb/refl_crc_unit_bench.sv
`timescale 1ns/1ps
module refl_crc_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgEnable = 1'b0;
  logic [1:0]  cfgPolySel = 2'd0;
  logic        cfgCompare = 1'b0;
  logic        startPulse = 1'b0;
  logic        beatValid = 1'b0;
  logic [31:0] beatData = '0;
  logic [1:0]  beatWidth = 2'd0;
  logic        beatLast = 1'b0;
  logic [31:0] expectedCrc = '0;
  logic        irqEnSet = 1'b0;
  logic        irqEnClr = 1'b0;
  logic [31:0] crcValue;
  logic        errStatus;
  logic        irqMask;
  logic        irqOut;

  int vecCount = 0;
  int badCount = 0;
  logic [31:0] model;

  always #2.5 clk = ~clk;

  refl_crc_unit u_refl_crc_unit (.*);

  function automatic logic [31:0] refRev(input logic [1:0] sel);
    if (sel == 2'd2) return 32'h00008408;
    if (sel == 2'd1) return 32'h82F63B78;
    return 32'hEDB88320;
  endfunction

  function automatic logic [31:0] refInit(input logic [1:0] sel);
    return (sel == 2'd2) ? 32'h0000FFFF : 32'hFFFFFFFF;
  endfunction

  function automatic int refBits(input logic [1:0] w);
    return (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] refStep(input logic [31:0] c, input logic [31:0] d,
                                          input logic [1:0] w, input logic [1:0] sel);
    logic [31:0] r;
    logic        b;
    r = c;
    for (int i = 0; i < refBits(w); i++) begin
      b = r[0] ^ d[i];
      r = r >> 1;
      if (b) r = r ^ refRev(sel);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      badCount++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic beat(input logic st, input logic vld, input logic [31:0] d,
                      input logic [1:0] w, input logic last);
    @(negedge clk);
    startPulse = st; beatValid = vld; beatData = d; beatWidth = w; beatLast = last;
    @(negedge clk);
    startPulse = 1'b0; beatValid = 1'b0; beatLast = 1'b0;
  endtask

  task automatic strobeMask(input logic s, input logic c);
    @(negedge clk);
    irqEnSet = s; irqEnClr = c;
    @(negedge clk);
    irqEnSet = 1'b0; irqEnClr = 1'b0;
  endtask

  task automatic runString(input logic [1:0] sel, input logic [31:0] golden, input string req);
    string s;
    s = "123456789";
    cfgPolySel = sel;
    for (int i = 0; i < 9; i++) beat(i == 0, 1'b1, {24'hA5C3E1, s[i]}, 2'd0, i == 8);
    check(req, crcValue, golden);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    badCount++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R9 crc reset", crcValue, 32'h0);
    check("R9 err/mask/irq reset", {29'd0, errStatus, irqMask, irqOut}, 32'h0);
    rst_n = 1'b1;
    cfgEnable = 1'b1;

    // R1 R2 R3: known string values; upper data bits carry garbage
    runString(2'd0, 32'h340BC6D9, "R1 R2 ethernet check string");
    runString(2'd1, 32'h1CF96D7C, "R2 castagnoli check string");
    runString(2'd2, 32'h00006F91, "R2 R3 ccitt16 check string");
    runString(2'd3, 32'h340BC6D9, "R2 code3 aliases ethernet");

    // R4 R10: start alone gives the preset
    cfgPolySel = 2'd2;
    crcValue_seed_check: begin
      beat(1'b1, 1'b0, 32'h0, 2'd0, 1'b0);
      check("R4 R10 ccitt preset", crcValue, 32'h0000FFFF);
    end
    cfgPolySel = 2'd1;
    beat(1'b1, 1'b0, 32'h0, 2'd0, 1'b0);
    check("R4 32-bit preset", crcValue, 32'hFFFFFFFF);

    // R3: halfword beat, upper garbage ignored
    beat(1'b1, 1'b1, 32'hDEAD1234, 2'd1, 1'b0);
    check("R3 halfword beat", crcValue, refStep(32'hFFFFFFFF, 32'h00001234, 2'd1, 2'd1));
    model = crcValue;

    // R5: disabled -> start and beat ignored
    cfgEnable = 1'b0;
    beat(1'b1, 1'b1, 32'h13572468, 2'd2, 1'b1);
    check("R5 hold when disabled", crcValue, model);
    cfgEnable = 1'b1;

    // R8 mask set, then R6 mismatch
    strobeMask(1'b1, 1'b0);
    check("R8 mask readback set", {31'd0, irqMask}, 32'd1);
    cfgPolySel = 2'd0; cfgCompare = 1'b1;
    model = refStep(32'hFFFFFFFF, 32'h89ABCDEF, 2'd2, 2'd0);
    expectedCrc = model ^ 32'h00000100;
    beat(1'b1, 1'b1, 32'h89ABCDEF, 2'd2, 1'b1);
    check("R6 mismatch sets err", {30'd0, errStatus, irqOut}, 32'd3);
    // R7 sticky across further beats
    beat(1'b0, 1'b1, 32'h55, 2'd0, 1'b0);
    check("R7 err sticky", {31'd0, errStatus}, 32'd1);
    // R8 both strobes: clear wins
    strobeMask(1'b1, 1'b1);
    check("R8 clear wins, irq masked", {30'd0, irqMask, irqOut}, 32'd0);
    check("R8 err kept while masked", {31'd0, errStatus}, 32'd1);
    strobeMask(1'b1, 1'b0);
    // R7 start clears; R6 match leaves clear
    model = refStep(32'hFFFFFFFF, 32'h00C0FFEE, 2'd2, 2'd0);
    expectedCrc = model;
    beat(1'b1, 1'b1, 32'h00C0FFEE, 2'd2, 1'b1);
    check("R6 R7 match after start clears", {30'd0, errStatus, irqOut}, 32'd0);
    // R7 mismatch in the start cycle wins
    expectedCrc = ~model;
    beat(1'b1, 1'b1, 32'h00C0FFEE, 2'd2, 1'b1);
    check("R7 set beats clear", {31'd0, errStatus}, 32'd1);
    // R6 16-bit compare ignores upper expected bits
    cfgPolySel = 2'd2;
    model = refStep(32'h0000FFFF, 32'h9876, 2'd1, 2'd2);
    expectedCrc = {16'hBEEF, model[15:0]};
    beat(1'b1, 1'b1, 32'h00009876, 2'd1, 1'b1);
    check("R6 16-bit masked compare", {31'd0, errStatus}, 32'd0);

    // random frames
    for (int f = 0; f < 60; f++) begin
      logic [1:0]  sel;
      logic        cmp;
      logic        corrupt;
      int          nb;
      sel = 2'($urandom_range(0, 3));
      cmp = 1'($urandom_range(0, 1));
      corrupt = 1'($urandom_range(0, 1));
      nb = $urandom_range(1, 8);
      cfgPolySel = sel; cfgCompare = cmp;
      model = refInit(sel);
      for (int b = 0; b < nb; b++) begin
        logic [31:0] d;
        logic [1:0]  w;
        d = $urandom();
        w = 2'($urandom_range(0, 3));
        model = refStep(model, d, w, sel);
        if (b == nb - 1) begin
          int pos;
          pos = $urandom_range(0, (sel == 2'd2) ? 15 : 31);
          expectedCrc = corrupt ? (model ^ (32'd1 << pos)) : model;
        end
        beat(b == 0, 1'b1, d, w, b == nb - 1);
        check("R1 R3 random beat", crcValue, model);
        if (sel == 2'd2) check("R10 random upper zero", {16'd0, crcValue[31:16]}, 32'd0);
      end
      check("R6 random compare", {30'd0, errStatus, irqOut},
            {30'd0, cmp & corrupt, cmp & corrupt});
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
    $finish;
  end

endmodule